// File: doc/BRIEF.md
# SDRAM Refresh Timer and Sequencer

This block keeps an SDRAM array refreshed without software involvement. A 12-bit down-counter, reloaded from a programmable cycle count, raises a refresh demand at a fixed period. A small command sequencer turns each demand into an auto-refresh command on the SDRAM control pins. While the refresh and its recovery window are in progress, it withholds the grant that lets an external memory-access arbiter start a transfer. The interval value is taken only when the counter reloads, so a new value written while refresh is running takes effect one period late. Dropping the enable and raising it again restarts the count from the value present at that moment.

Software can also ask for a precharge-all or an auto-refresh at any time through a 3-bit command code and a strobe. Setting the refresh-mode bit while refresh is enabled puts the memory into self-refresh: the block issues the entry command with CKE low and reports the state on a status output. Clearing the mode bit brings the memory back. CKE rises, NOPs fill the exit recovery time, the status clears, and one auto-refresh is issued before access is allowed again.

Top module: `sdram_refresh_seq`

## Requirements
- R1: With refresh enabled and the interval N larger than TRC_CYC+GAP_CYC+1, auto-refresh commands appear exactly N cycles apart. The first one appears on the pins after the (N+2)th rising edge, counting the first edge that samples the enable high.
- R2: An interval written while refresh stays enabled does not shorten or lengthen the countdown already running. The gap to the next refresh uses the old value, and the gap after that uses the new one.
- R3: After the enable is dropped, no refresh is issued. When it is raised again, the first refresh follows the interval present in the cycle the enable was raised, with the R1 timing.
- R4: acc_gnt is high only when acc_req is high and the block is idle with nothing to issue. A refresh falling due wins over a held request: acc_gnt is low from the cycle the refresh becomes due for 1+TRC_CYC+GAP_CYC cycles.
- R5: Between any two commands other than NOP there are at least TRC_CYC+GAP_CYC+1 cycles: a hold time, then an idle gap.
- R6: A strobe with code 3'b010 issues precharge-all with sd_a10 high. Code 3'b100 issues auto-refresh. Any other code is ignored. A software command issued in the same cycle that a refresh falls due goes out after the refresh, TRC_CYC+GAP_CYC+1 cycles later.
- R7: The pins {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} only carry NOP 4'b0111, precharge 4'b0010 or refresh 4'b0001.
- R8: With both the enable and the mode bit high, the block enters self-refresh. It issues refresh 4'b0001 in the cycle CKE first goes low, raises self_stat, then holds CKE low with NOPs. CKE is never low outside self-refresh.
- R9: Clearing the mode bit raises CKE while self_stat is still high. TXSR_CYC+1 NOP cycles follow, with self_stat clearing in the last one. Then exactly one auto-refresh is issued.
- R10: A refresh that falls due while a previous one is still held off is kept as one pending request and never dropped. With an interval shorter than the hold, refreshes follow each other every TRC_CYC+GAP_CYC+1 cycles.
- R11: In reset the pins show NOP, CKE is high and self_stat is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_interval | input | 12 | Refresh period in clock cycles |
| cfg_ref_en | input | 1 | Periodic refresh enable |
| cfg_self_mode | input | 1 | Request self-refresh (acts when cfg_ref_en is high) |
| sw_cmd | input | 3 | Software command code |
| sw_cmd_stb | input | 1 | One-cycle strobe for sw_cmd |
| acc_req | input | 1 | Memory-access request from the arbiter |
| acc_gnt | output | 1 | Permission to start the access |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_a10 | output | 1 | Address bit 10, high for precharge-all |
| sd_cke | output | 1 | SDRAM clock enable |
| self_stat | output | 1 | Memory is in self-refresh |

## Verification
Two functions can land in the same cycle: a periodic refresh falling due and a software command strobe. The strobe is also competing with an access request held high. The bench counts the cycles since the last observed refresh and drives a precharge-all strobe in the exact cycle the next refresh becomes due. It then expects the refresh on the following cycle and the precharge exactly one hold-plus-gap window later, with the grant low throughout. Random intervals and randomly toggled access requests then confirm that the refresh period never bends to the arbiter.

// File: rtl/sdr_ref_pkg.sv
// Shared encodings for the refresh sequencer.
// Assumes SDRAM control pins are ordered {cs_n, ras_n, cas_n, we_n}.
package sdr_ref_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_GAP,
        ST_SELF,
        ST_XSR
    } seq_st_e;

    localparam logic [2:0] SWC_PALL = 3'b010;
    localparam logic [2:0] SWC_CBR  = 3'b100;

endpackage

// File: rtl/sdr_ref_timer.sv
// Periodic refresh demand generator.
// Loads the interval when the enable rises and again at each expiry, so a
// changed interval only matters from the next reload. Emits a one-cycle due.
// An interval of 0 or 1 fires every cycle.
module sdr_ref_timer #(
    parameter int INTV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [INTV_W-1:0] intv,
    output logic              due
);

    logic [INTV_W-1:0] cnt_q;
    logic              en_q;

    // Count down, reload on expiry or on a fresh enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
            due   <= 1'b0;
        end else begin
            en_q <= en;
            due  <= 1'b0;
            if (!en) begin
                cnt_q <= '0;
            end else if (!en_q) begin
                cnt_q <= intv;
            end else if (cnt_q <= INTV_W'(1)) begin
                cnt_q <= intv;
                due   <= 1'b1;
            end else begin
                cnt_q <= cnt_q - INTV_W'(1);
            end
        end
    end

endmodule

// File: rtl/sdr_cmd_seq.sv
// Command sequencer: issues refresh, software and self-refresh commands.
// Priority in idle: pending refresh, then software command, then self entry.
// Every command is followed by TRC_CYC hold cycles and GAP_CYC idle cycles.
// Assumes TRC_CYC >= 1 and TXSR_CYC >= 1.
module sdr_cmd_seq
    import sdr_ref_pkg::*;
#(
    parameter int TRC_CYC  = 6,
    parameter int GAP_CYC  = 3,
    parameter int TXSR_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       due,
    input  logic       ref_en,
    input  logic       self_mode,
    input  logic [2:0] sw_cmd,
    input  logic       sw_stb,
    input  logic       acc_req,
    output logic       acc_gnt,
    output sd_cmd_e    cmd_q,
    output logic       a10_q,
    output logic       cke_q,
    output logic       stat_q
);

    localparam int MAX_AB = (TRC_CYC > GAP_CYC) ? TRC_CYC : GAP_CYC;
    localparam int MAXC   = (MAX_AB > TXSR_CYC) ? MAX_AB : TXSR_CYC;
    localparam int CNT_W  = $clog2(MAXC + 1);

    seq_st_e         st_q;
    logic [CNT_W-1:0] cnt_q;
    logic            pend_q;
    logic            swp_q;
    logic [2:0]      swc_q;
    logic            req_any;
    logic            sw_ok;
    logic            self_go;

    // Decode of the pending work seen by the idle state.
    always_comb begin
        req_any = pend_q | due;
        sw_ok   = (sw_cmd == SWC_PALL) || (sw_cmd == SWC_CBR);
        self_go = ref_en && self_mode;
        acc_gnt = acc_req && (st_q == ST_IDLE) && !req_any && !swp_q && !self_go;
    end

    // State, timing counter, pending flags and registered pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            pend_q <= 1'b0;
            swp_q  <= 1'b0;
            swc_q  <= '0;
            cmd_q  <= CMD_NOP;
            a10_q  <= 1'b0;
            cke_q  <= 1'b1;
            stat_q <= 1'b0;
        end else begin
            cmd_q  <= CMD_NOP;
            a10_q  <= 1'b0;
            pend_q <= pend_q | due;
            if (sw_stb && sw_ok && !swp_q && st_q != ST_SELF && st_q != ST_XSR) begin
                swp_q <= 1'b1;
                swc_q <= sw_cmd;
            end
            case (st_q)
                ST_IDLE: begin
                    if (req_any) begin
                        cmd_q  <= CMD_REF;
                        pend_q <= 1'b0;
                        st_q   <= ST_HOLD;
                        cnt_q  <= CNT_W'(TRC_CYC - 1);
                    end else if (swp_q) begin
                        swp_q <= 1'b0;
                        st_q  <= ST_HOLD;
                        cnt_q <= CNT_W'(TRC_CYC - 1);
                        if (swc_q == SWC_PALL) begin
                            cmd_q <= CMD_PRE;
                            a10_q <= 1'b1;
                        end else begin
                            cmd_q <= CMD_REF;
                        end
                    end else if (self_go) begin
                        cmd_q  <= CMD_REF;
                        cke_q  <= 1'b0;
                        stat_q <= 1'b1;
                        pend_q <= 1'b0;
                        st_q   <= ST_SELF;
                    end
                end
                ST_HOLD: begin
                    if (cnt_q == '0) begin
                        if (GAP_CYC == 0) begin
                            st_q <= ST_IDLE;
                        end else begin
                            st_q  <= ST_GAP;
                            cnt_q <= CNT_W'(GAP_CYC - 1);
                        end
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_GAP: begin
                    if (cnt_q == '0) st_q <= ST_IDLE;
                    else             cnt_q <= cnt_q - CNT_W'(1);
                end
                ST_SELF: begin
                    pend_q <= 1'b0;
                    if (!self_mode) begin
                        cke_q <= 1'b1;
                        st_q  <= ST_XSR;
                        cnt_q <= CNT_W'(TXSR_CYC - 1);
                    end
                end
                ST_XSR: begin
                    pend_q <= 1'b0;
                    if (cnt_q == '0) begin
                        stat_q <= 1'b0;
                        pend_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdram_refresh_seq.sv
// Top of the SDRAM refresh timer and sequencer.
// Connects the interval timer to the command sequencer and maps the
// sequencer command onto the four active-low SDRAM control pins.
module sdram_refresh_seq
    import sdr_ref_pkg::*;
#(
    parameter int INTV_W   = 12,
    parameter int TRC_CYC  = 6,
    parameter int GAP_CYC  = 3,
    parameter int TXSR_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INTV_W-1:0] cfg_interval,
    input  logic              cfg_ref_en,
    input  logic              cfg_self_mode,
    input  logic [2:0]        sw_cmd,
    input  logic              sw_cmd_stb,
    input  logic              acc_req,
    output logic              acc_gnt,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_a10,
    output logic              sd_cke,
    output logic              self_stat
);

    logic    due;
    sd_cmd_e cmd;

    sdr_ref_timer #(.INTV_W(INTV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_ref_en),
        .intv  (cfg_interval),
        .due   (due)
    );

    sdr_cmd_seq #(
        .TRC_CYC  (TRC_CYC),
        .GAP_CYC  (GAP_CYC),
        .TXSR_CYC (TXSR_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .due       (due),
        .ref_en    (cfg_ref_en),
        .self_mode (cfg_self_mode),
        .sw_cmd    (sw_cmd),
        .sw_stb    (sw_cmd_stb),
        .acc_req   (acc_req),
        .acc_gnt   (acc_gnt),
        .cmd_q     (cmd),
        .a10_q     (sd_a10),
        .cke_q     (sd_cke),
        .stat_q    (self_stat)
    );

    // Pin mapping of the registered command.
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: rtl/sdram_refresh_seq_chk.sv
// Property checker for sdram_refresh_seq, attached by bind.
// Watches only the top-level ports; the spacing window uses a counter.
module sdram_refresh_seq_chk #(
    parameter int TRC_CYC = 6,
    parameter int GAP_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic acc_req,
    input logic acc_gnt,
    input logic sd_cs_n,
    input logic sd_ras_n,
    input logic sd_cas_n,
    input logic sd_we_n,
    input logic sd_a10,
    input logic sd_cke,
    input logic self_stat
);

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;
    localparam int MIN_SP = TRC_CYC + GAP_CYC + 1;

    logic [3:0] pins;
    logic [7:0] since_q;

    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // Cycles since the last non-NOP command, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)             since_q <= 8'hFF;
        else if (pins != NOP)   since_q <= 8'd1;
        else if (since_q != 8'hFF) since_q <= since_q + 8'd1;
    end

    p_legal_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == NOP) || (pins == PRE) || (pins == REF));

    p_cmd_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pins != NOP) |-> (since_q >= 8'(MIN_SP)));

    p_gnt_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> (acc_req && pins == NOP));

    p_pre_a10_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == PRE) |-> sd_a10);

    p_cke_low_self_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cke |-> self_stat);

    p_entry_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_cke) |-> (pins == REF));

    p_exit_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_cke) |-> self_stat);

endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(
    .TRC_CYC (TRC_CYC),
    .GAP_CYC (GAP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_req   (acc_req),
    .acc_gnt   (acc_gnt),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_a10    (sd_a10),
    .sd_cke    (sd_cke),
    .self_stat (self_stat)
);

// File: tb/sdram_refresh_seq_tb.sv
// Self-checking bench: directed corner cases plus random intervals.
module sdram_refresh_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TRC  = 6;
    localparam int GAP  = 3;
    localparam int TXSR = 8;
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] cfg_interval;
    logic        cfg_ref_en, cfg_self_mode;
    logic [2:0]  sw_cmd;
    logic        sw_cmd_stb, acc_req;
    logic        acc_gnt, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic        sd_a10, sd_cke, self_stat;
    logic [3:0]  cmd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_refresh_seq #(.TRC_CYC(TRC), .GAP_CYC(GAP), .TXSR_CYC(TXSR)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
        .cfg_ref_en(cfg_ref_en), .cfg_self_mode(cfg_self_mode),
        .sw_cmd(sw_cmd), .sw_cmd_stb(sw_cmd_stb), .acc_req(acc_req),
        .acc_gnt(acc_gnt), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a10(sd_a10),
        .sd_cke(sd_cke), .self_stat(self_stat)
    );

    function automatic int first_gap(input int n);
        return n + 2;
    endfunction

    function automatic int busy_gap();
        return TRC + GAP + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Cycles until the next refresh command; checks the grant rule on the way.
    task automatic wait_ref(output int n, input bit rnd);
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (acc_gnt && (!acc_req || cmd != NOP)) chk(1'b0, "R4 grant", 1, 0);
            if (cmd == REF || n >= 400) break;
            if (rnd) acc_req = 1'($urandom % 2);
        end
    endtask

    task automatic idle_cycles(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        int low;
        int bad;
        void'($urandom(32'h5EED_0123));
        rst_n = 1'b0; cfg_interval = 12'd0; cfg_ref_en = 1'b0;
        cfg_self_mode = 1'b0; sw_cmd = 3'd0; sw_cmd_stb = 1'b0; acc_req = 1'b1;
        idle_cycles(3);
        chk(cmd == NOP, "R11 pins", cmd, NOP);
        chk(sd_cke == 1'b1, "R11 cke", sd_cke, 1);
        chk(self_stat == 1'b0, "R11 stat", self_stat, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acc_gnt == 1'b1, "R4 idle grant", acc_gnt, 1);

        // R1: first refresh and steady period
        cfg_interval = 12'd20; cfg_ref_en = 1'b1;
        wait_ref(n, 1'b0); chk(n == first_gap(20), "R1 first", n, first_gap(20));
        wait_ref(n, 1'b0); chk(n == 20, "R1 period", n, 20);

        // R2: interval rewritten while enabled
        cfg_interval = 12'd30;
        wait_ref(n, 1'b0); chk(n == 20, "R2 old interval", n, 20);
        wait_ref(n, 1'b0); chk(n == 30, "R2 new interval", n, 30);

        // R3: disable is quiet, re-enable uses current value
        cfg_ref_en = 1'b0;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cmd == REF) bad++;
        end
        chk(bad == 0, "R3 disabled", bad, 0);
        cfg_interval = 12'd25; cfg_ref_en = 1'b1;
        wait_ref(n, 1'b0); chk(n == first_gap(25), "R3 restart", n, first_gap(25));

        // R4: refresh preempts a held request
        while (!acc_gnt) @(negedge clk);
        while (acc_gnt) @(negedge clk);
        low = 0;
        while (!acc_gnt) begin low++; @(negedge clk); end
        chk(low == 1 + TRC + GAP, "R4 hold-off", low, 1 + TRC + GAP);

        // R10: interval shorter than the hold window
        cfg_ref_en = 1'b0; idle_cycles(20);
        cfg_interval = 12'd5; cfg_ref_en = 1'b1;
        wait_ref(n, 1'b0); chk(n == first_gap(5), "R10 first", n, first_gap(5));
        for (int i = 0; i < 3; i++) begin
            wait_ref(n, 1'b0); chk(n == busy_gap(), "R10 back-to-back", n, busy_gap());
        end

        // R6: strobe lands in the cycle a refresh falls due
        cfg_ref_en = 1'b0; idle_cycles(20);
        cfg_interval = 12'd30; cfg_ref_en = 1'b1;
        wait_ref(n, 1'b0); chk(n == first_gap(30), "R1 first", n, first_gap(30));
        idle_cycles(29);
        chk(acc_gnt == 1'b0, "R4 due cycle", acc_gnt, 0);
        sw_cmd = 3'b010; sw_cmd_stb = 1'b1;
        @(negedge clk);
        sw_cmd_stb = 1'b0;
        chk(cmd == REF, "R6 refresh first", cmd, REF);
        bad = 0;
        for (int k = 1; k <= busy_gap(); k++) begin
            @(negedge clk);
            if (acc_gnt) bad++;
            if (k < busy_gap() && cmd != NOP) bad++;
        end
        chk(bad == 0, "R5 quiet window", bad, 0);
        chk(cmd == PRE && sd_a10, "R6 precharge after refresh", cmd, PRE);

        // R6: software commands alone, and an ignored code
        cfg_ref_en = 1'b0; idle_cycles(20);
        sw_cmd = 3'b010; sw_cmd_stb = 1'b1;
        @(negedge clk); sw_cmd_stb = 1'b0;
        chk(cmd == NOP, "R6 latency", cmd, NOP);
        @(negedge clk);
        chk(cmd == PRE, "R6 precharge", cmd, PRE);
        chk(sd_a10 == 1'b1, "R6 a10", sd_a10, 1);
        idle_cycles(15);
        sw_cmd = 3'b100; sw_cmd_stb = 1'b1;
        @(negedge clk); sw_cmd_stb = 1'b0;
        @(negedge clk);
        chk(cmd == REF, "R6 software refresh", cmd, REF);
        idle_cycles(15);
        sw_cmd = 3'b111; sw_cmd_stb = 1'b1;
        @(negedge clk); sw_cmd_stb = 1'b0;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cmd != NOP) bad++;
        end
        chk(bad == 0, "R6 ignored code", bad, 0);

        // R8/R9: self-refresh entry and exit
        cfg_interval = 12'd40; cfg_ref_en = 1'b1; idle_cycles(5);
        cfg_self_mode = 1'b1;
        n = 0;
        while (sd_cke && n < 200) begin @(negedge clk); n++; end
        chk(cmd == REF, "R8 entry command", cmd, REF);
        chk(self_stat == 1'b1, "R8 status", self_stat, 1);
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sd_cke || cmd != NOP) bad++;
        end
        chk(bad == 0, "R8 hold low", bad, 0);
        cfg_self_mode = 1'b0;
        @(negedge clk);
        chk(sd_cke == 1'b1 && self_stat == 1'b1, "R9 cke rises", sd_cke, 1);
        n = 1;
        forever begin
            @(negedge clk);
            if (cmd == REF || n > 100) break;
            n++;
        end
        chk(n == TXSR + 1, "R9 exit NOPs", n, TXSR + 1);
        chk(self_stat == 1'b0, "R9 status cleared", self_stat, 0);

        // R1/R4: random intervals with a toggling access request
        for (int it = 0; it < 16; it++) begin
            int ni;
            cfg_ref_en = 1'b0; acc_req = 1'b1; idle_cycles(15);
            ni = 12 + int'($urandom % 60);
            cfg_interval = 12'(ni); cfg_ref_en = 1'b1;
            wait_ref(n, 1'b1); chk(n == first_gap(ni), "R1 random first", n, first_gap(ni));
            wait_ref(n, 1'b1); chk(n == ni, "R1 random period", n, ni);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule